// File: doc/BRIEF.md
# External Trigger and Veto Encoder

This block turns single-cycle event pulses from the external connectors into trigger-primitive records for the trigger FIFO. An event is a strobe bit sampled on a rising clock edge. A two-bit kind field says whether the event is an external trigger, the start of a veto or the end of a veto. External triggers also carry a source index. Each accepted event produces exactly one 72-bit record, qualified by a valid bit, one cycle after the edge that sampled it.

The block does not generate the 32-bit sample timestamp: it reads it as an input and copies it into each record unchanged. Every record holds four fields: the timestamp taken on the strobe edge, a 16-bit code naming the event, a 16-bit trigger word of zeros and an 8-bit logic field of ones. The output has no backpressure. Strobes on consecutive cycles therefore produce records on consecutive cycles.

Top module: `etv_encoder`

## Requirements
- R1: While `rst` is high, `rec_valid` is 0 and every strobe is ignored. Asserting `rst` clears `rec_valid` at once. A strobe sampled on an edge where `rst` is high never produces a record.
- R2: A strobe with kind 2'b01 (veto start) produces a record whose code field, bits 39:24, equals 1.
- R3: A strobe with kind 2'b10 (veto stop) produces a record whose code field equals 2.
- R4: A strobe with kind 2'b11 (external trigger) produces a record whose code field equals 3 plus `evt_src`.
- R5: If 3 plus `evt_src` does not fit in 16 bits, the external-trigger code saturates at 16'hFFFF.
- R6: Bits 71:40 of the record equal the `ts` value sampled on the same edge as the strobe. The record appears with `rec_valid` high in the cycle after that edge.
- R7: In every valid record, bits 23:8 are all zeros and bits 7:0 are all ones.
- R8: `rec_valid` is high for exactly one cycle per accepted strobe. A low strobe, or a strobe with kind 2'b00, produces no record.
- R9: Strobes on consecutive cycles produce records on consecutive cycles, each one matching its own event.
- R10: `evt_src` has no effect on veto records: their code stays 1 or 2 whatever the source index is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | Asynchronous active-high reset |
| evt_stb | input | 1 | Event strobe, sampled on the rising edge |
| evt_kind | input | 2 | 00 none, 01 veto start, 10 veto stop, 11 external trigger |
| evt_src | input | 16 | External trigger source index |
| ts | input | 32 | Current sample timestamp |
| rec_valid | output | 1 | Record qualifier, high for one cycle per event |
| rec_data | output | 72 | Record: timestamp, code, zero word, ones field |

## Verification
Two functions can fall in the same cycle.

The first pair is emitting one record while accepting the next strobe. The bench drives a run of strobes on consecutive edges, changing the kind, source and timestamp on every edge. It then checks each cycle's record against the event sampled one edge before it. If a record were held over or merged, it would show as a wrong code or a wrong timestamp.

The second pair is reset arriving together with a strobe. The bench asserts reset while a strobe is pending. It checks that the output drops at once, that no record appears during reset or in the cycle after release, and that normal recording resumes afterwards.

// File: rtl/etv_pkg.sv
package etv_pkg;

  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_VSTART = 2'b01,
    EV_VSTOP  = 2'b10,
    EV_XTRIG  = 2'b11
  } ev_kind_e;

  localparam int unsigned CODE_VETO_START = 1;
  localparam int unsigned CODE_VETO_STOP  = 2;
  localparam int unsigned CODE_XTRIG_BASE = 3;

endpackage

// File: rtl/etv_classify.sv
module etv_classify
  import etv_pkg::*;
#(
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned CODE_W = 16
) (
  input  logic              rst,
  input  logic              stb,
  input  logic [1:0]        kind,
  input  logic [SRC_W-1:0]  src,
  output logic              accept,
  output logic [CODE_W-1:0] code
);

  localparam int unsigned SUM_W = ((SRC_W > CODE_W) ? SRC_W : CODE_W) + 1;

  // Source index plus the trigger base, clamped to the largest code.
  function automatic logic [CODE_W-1:0] xtrig_code(input logic [SRC_W-1:0] idx);
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] limit;
    sum   = SUM_W'(idx) + SUM_W'(CODE_XTRIG_BASE);
    limit = SUM_W'({CODE_W{1'b1}});
    if (sum > limit) return {CODE_W{1'b1}};
    return sum[CODE_W-1:0];
  endfunction

  ev_kind_e kind_e;
  assign kind_e = ev_kind_e'(kind);

  always_comb begin
    unique case (kind_e)
      EV_VSTART: code = CODE_W'(CODE_VETO_START);
      EV_VSTOP:  code = CODE_W'(CODE_VETO_STOP);
      EV_XTRIG:  code = xtrig_code(src);
      default:   code = '0;
    endcase
  end

  assign accept = stb && !rst && (kind_e != EV_NONE);

endmodule

// File: rtl/etv_pack.sv
module etv_pack #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned CODE_W = 16,
  parameter int unsigned ZERO_W = 16,
  parameter int unsigned ONES_W = 8,
  localparam int unsigned REC_W = TS_W + CODE_W + ZERO_W + ONES_W
) (
  input  logic [TS_W-1:0]   stamp,
  input  logic [CODE_W-1:0] code,
  output logic [REC_W-1:0]  rec
);

  function automatic logic [REC_W-1:0] build(input logic [TS_W-1:0] t,
                                             input logic [CODE_W-1:0] c);
    return {t, c, {ZERO_W{1'b0}}, {ONES_W{1'b1}}};
  endfunction

  assign rec = build(stamp, code);

endmodule

// File: rtl/etv_outreg.sv
module etv_outreg #(
  parameter int unsigned REC_W = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REC_W-1:0] rec_in,
  output logic             valid,
  output logic [REC_W-1:0] data
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= load;
      if (load) data <= rec_in;
    end
  end

endmodule

// File: rtl/etv_encoder.sv
module etv_encoder #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned CODE_W = 16,
  parameter int unsigned ZERO_W = 16,
  parameter int unsigned ONES_W = 8,
  parameter int unsigned SRC_W  = 16,
  localparam int unsigned REC_W = TS_W + CODE_W + ZERO_W + ONES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_stb,
  input  logic [1:0]        evt_kind,
  input  logic [SRC_W-1:0]  evt_src,
  input  logic [TS_W-1:0]   ts,
  output logic              rec_valid,
  output logic [REC_W-1:0]  rec_data
);

  // Named internal events, also observed by the checker.
  logic              ev_accept;
  logic [CODE_W-1:0] ev_code;
  logic [REC_W-1:0]  ev_record;

  etv_classify #(.SRC_W(SRC_W), .CODE_W(CODE_W)) u_cls (
    .rst    (rst),
    .stb    (evt_stb),
    .kind   (evt_kind),
    .src    (evt_src),
    .accept (ev_accept),
    .code   (ev_code)
  );

  etv_pack #(.TS_W(TS_W), .CODE_W(CODE_W), .ZERO_W(ZERO_W), .ONES_W(ONES_W)) u_pack (
    .stamp (ts),
    .code  (ev_code),
    .rec   (ev_record)
  );

  etv_outreg #(.REC_W(REC_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (ev_accept),
    .rec_in (ev_record),
    .valid  (rec_valid),
    .data   (rec_data)
  );

endmodule

// File: rtl/etv_checker.sv
module etv_checker #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned CODE_W = 16,
  parameter int unsigned ZERO_W = 16,
  parameter int unsigned ONES_W = 8,
  parameter int unsigned SRC_W  = 16,
  localparam int unsigned REC_W = TS_W + CODE_W + ZERO_W + ONES_W
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_stb,
  input logic [1:0]        evt_kind,
  input logic [SRC_W-1:0]  evt_src,
  input logic [TS_W-1:0]   ts,
  input logic              ev_accept,
  input logic              rec_valid,
  input logic [REC_W-1:0]  rec_data
);

  localparam int unsigned SUM_W = ((SRC_W > CODE_W) ? SRC_W : CODE_W) + 1;
  localparam int unsigned CODE_LSB = ZERO_W + ONES_W;

  logic [CODE_W-1:0] code_f;
  logic [TS_W-1:0]   ts_f;
  assign code_f = rec_data[CODE_LSB +: CODE_W];
  assign ts_f   = rec_data[REC_W-1 -: TS_W];

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rec_valid);

  a_r8_valid_needs_event: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ($past(evt_stb) && $past(evt_kind) != 2'b00 && !$past(rst)));

  a_r8_accept_gives_record: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> rec_valid);

  a_r6_stamp: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ts_f == $past(ts));

  a_r7_filler: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> rec_data[CODE_LSB-1:0] == {{ZERO_W{1'b0}}, {ONES_W{1'b1}}});

  a_r2_vstart_code: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && $past(evt_kind) == 2'b01) |-> code_f == CODE_W'(1));

  a_r3_vstop_code: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && $past(evt_kind) == 2'b10) |-> code_f == CODE_W'(2));

  a_r4_xtrig_code: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && $past(evt_kind) == 2'b11 &&
     (SUM_W'($past(evt_src)) + SUM_W'(3)) <= SUM_W'({CODE_W{1'b1}}))
    |-> SUM_W'(code_f) == SUM_W'($past(evt_src)) + SUM_W'(3));

  a_r5_xtrig_saturate: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && $past(evt_kind) == 2'b11 &&
     (SUM_W'($past(evt_src)) + SUM_W'(3)) > SUM_W'({CODE_W{1'b1}}))
    |-> code_f == {CODE_W{1'b1}});

endmodule

bind etv_encoder etv_checker #(
  .TS_W(TS_W), .CODE_W(CODE_W), .ZERO_W(ZERO_W), .ONES_W(ONES_W), .SRC_W(SRC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_stb   (evt_stb),
  .evt_kind  (evt_kind),
  .evt_src   (evt_src),
  .ts        (ts),
  .ev_accept (ev_accept),
  .rec_valid (rec_valid),
  .rec_data  (rec_data)
);

// File: tb/sim_etv_encoder.sv
module sim_etv_encoder;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        evt_stb;
  logic [1:0]  evt_kind;
  logic [15:0] evt_src;
  logic [31:0] ts;
  logic        rec_valid;
  logic [71:0] rec_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  etv_encoder u0 (
    .clk(clk), .rst(rst), .evt_stb(evt_stb), .evt_kind(evt_kind),
    .evt_src(evt_src), .ts(ts), .rec_valid(rec_valid), .rec_data(rec_data)
  );

  function automatic logic [15:0] want_code(input logic [1:0] k, input logic [15:0] s);
    int unsigned v;
    if (k == 2'b01) return 16'd1;
    if (k == 2'b10) return 16'd2;
    v = int'(s) + 3;
    if (v > 65535) return 16'hFFFF;
    return v[15:0];
  endfunction

  function automatic logic [71:0] want_rec(input logic [1:0] k, input logic [15:0] s,
                                           input logic [31:0] t);
    return {t, want_code(k, s), 16'h0000, 8'hFF};
  endfunction

  task automatic check(input string req, input logic ev, input logic [71:0] ed);
    n_checks++;
    if (rec_valid !== ev || (ev && rec_data !== ed)) begin
      n_fail++;
      $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
               req, rec_valid, rec_data, ev, ed);
    end
  endtask

  task automatic idle_inputs();
    evt_stb = 0; evt_kind = 2'b00; evt_src = '0;
  endtask

  // Apply one event on the next edge and check the record after it.
  task automatic one_event(input string req, input logic [1:0] k,
                           input logic [15:0] s, input logic [31:0] t);
    @(negedge clk);
    evt_stb = 1; evt_kind = k; evt_src = s; ts = t;
    @(posedge clk); #1;
    check(req, 1'b1, want_rec(k, s, t));
    @(negedge clk);
    idle_inputs(); ts = t + 1;
    @(posedge clk); #1;
    check({req, " single cycle R8"}, 1'b0, '0);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check("R1 valid low in reset", 1'b0, '0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check("R1 valid low after release", 1'b0, '0);
  endtask

  task automatic t_vetoes();
    one_event("R2 veto start", 2'b01, 16'd0, 32'h0000_1000);
    one_event("R3 veto stop", 2'b10, 16'd0, 32'hFFFF_FFFF);
    one_event("R10 veto start ignores src", 2'b01, 16'hBEEF, 32'h1234_5678);
    one_event("R10 veto stop ignores src", 2'b10, 16'hFFFF, 32'h0BAD_F00D);
  endtask

  task automatic t_xtrig();
    one_event("R4 xtrig src 0", 2'b11, 16'd0, 32'h0000_0001);
    one_event("R4 xtrig src 41", 2'b11, 16'd41, 32'h8000_0000);
    one_event("R4 xtrig src at limit", 2'b11, 16'hFFFC, 32'hA5A5_5A5A);
    one_event("R5 xtrig saturates src FFFD", 2'b11, 16'hFFFD, 32'h0000_00FF);
    one_event("R5 xtrig saturates src FFFF", 2'b11, 16'hFFFF, 32'hCAFE_0001);
  endtask

  task automatic t_no_event();
    @(negedge clk);
    evt_stb = 1; evt_kind = 2'b00; evt_src = 16'h7; ts = 32'h55;
    @(posedge clk); #1;
    check("R8 kind 00 gives no record", 1'b0, '0);
    @(negedge clk);
    evt_stb = 0; evt_kind = 2'b11;
    @(posedge clk); #1;
    check("R8 strobe low gives no record", 1'b0, '0);
    @(negedge clk); idle_inputs();
  endtask

  task automatic t_back_to_back();
    logic [1:0]  ks [4] = '{2'b11, 2'b01, 2'b11, 2'b10};
    logic [15:0] ss [4] = '{16'd5, 16'd9, 16'hFFFE, 16'd1};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      evt_stb = 1; evt_kind = ks[i]; evt_src = ss[i]; ts = 32'h100 + 32'(i * 7);
      @(posedge clk); #1;
      check($sformatf("R9 back-to-back record %0d R6", i), 1'b1,
            want_rec(ks[i], ss[i], 32'h100 + 32'(i * 7)));
    end
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    check("R9 run ends cleanly", 1'b0, '0);
  endtask

  task automatic t_reset_with_strobe();
    @(negedge clk);
    evt_stb = 1; evt_kind = 2'b10; ts = 32'h77;
    @(posedge clk); #1;
    check("R1 pre-reset record", 1'b1, want_rec(2'b10, 16'd0, 32'h77));
    #2 rst = 1; #1;
    check("R1 reset clears valid at once", 1'b0, '0);
    @(posedge clk); #1;
    check("R1 strobe in reset ignored", 1'b0, '0);
    @(negedge clk); rst = 0; idle_inputs();
    @(posedge clk); #1;
    check("R1 nothing after release", 1'b0, '0);
    one_event("R1 resumes after reset", 2'b11, 16'd2, 32'h9999);
  endtask

  initial begin
    rst = 1; ts = '0; idle_inputs();
    repeat (2) @(posedge clk);
    t_reset();
    t_vetoes();
    t_xtrig();
    t_no_event();
    t_back_to_back();
    t_reset_with_strobe();
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule